// File: doc/BRIEF.md
# Memory Die Repair-State Classifier

This block sits after the self-test and redundancy-analysis pass of a memory die. For each tested die it receives a result packet with these fields:

- a die identifier;
- a flag saying whether any fault was seen;
- a flag saying whether the repair succeeded;
- a flag saying whether spares borrowed from the stacked neighbour were needed;
- signed row and column spare states;
- a count of isolated single-cell faults.

Each spare state is signed. A positive value is the number of spares left unused. A negative value is the number of spares the die is short of.

The block sorts each die into one of four repair classes. It counts every class. Dies that can still go into a stack are appended to a small record table, which a later pairing stage reads through an index port.

The control is a two-state machine. In `ST_IDLE` the block is ready. Transition *accept* (`in_valid` high in `ST_IDLE`) captures the packet and moves to `ST_JUDGE`. In `ST_JUDGE` the packet is classified, the class counter is bumped and, if the die is usable and the table has room, one record is written. Transition *retire* then always returns to `ST_IDLE`. While in `ST_JUDGE`, `in_ready` is low and the strobe is ignored.

Top module: `die_class_recorder`

## Requirements
- R1: After reset, `in_ready` is 1, `rec_count` is 0, `full` is 0 and all four class counters are 0.
- R2: A die with `in_fault`=0 gets class code 0 (fault-free) and is stored with row state equal to SPARE_ROWS, column state equal to SPARE_COLS and single-cell count 0, whatever its input states.
- R3: A die with `in_fault`=1 and `in_repaired`=0 gets class code 3 (irreparable) and is not written to the table.
- R4: A die with `in_fault`=1, `in_repaired`=1 and `in_inter`=0 gets class code 1 (self-repairable) and is stored with its input states and count unchanged.
- R5: A die with `in_fault`=1, `in_repaired`=1 and `in_inter`=1 gets class code 2 (inter-repairable) and is stored with its input states and count unchanged.
- R6: A repaired die whose row state is below -SPARE_ROWS or whose column state is below -SPARE_COLS gets class code 3 and is not stored. States exactly at -SPARE_ROWS and at -SPARE_COLS are kept.
- R7: The checks are applied in a fixed order: fault flag first, then repaired flag, then inter-die flag. A die with no fault is fault-free even when its repaired flag is 0.
- R8: A packet is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for exactly the next cycle. The counter and table updates are visible after the second edge.
- R9: Stored dies occupy table entries 0, 1, 2, … in arrival order, and `rec_count` gives how many are held. When `rec_count` reaches TABLE_DEPTH, `full` is 1 and further usable dies are not stored.
- R10: Each judged die increments exactly one class counter, `cnt_by_class[c]` for its class code c. This includes irreparable dies and dies dropped because the table is full.
- R11: `in_valid` seen while `in_ready` is 0 has no effect on counters or the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result packet strobe |
| in_ready | output | 1 | Block can take a packet |
| in_id | input | ID_W | Die identifier |
| in_fault | input | 1 | Fault was detected |
| in_repaired | input | 1 | Repair analysis succeeded |
| in_inter | input | 1 | Neighbour spares were used |
| in_row | input | RW | Signed spare-row state |
| in_col | input | CW | Signed spare-column state |
| in_scf | input | SCF_W | Single-cell fault count |
| rd_idx | input | IDX_W | Table read index |
| rd_id | output | ID_W | Stored die identifier |
| rd_class | output | 2 | Stored class code |
| rd_row | output | RW | Stored row state |
| rd_col | output | CW | Stored column state |
| rd_scf | output | SCF_W | Stored single-cell count |
| rec_count | output | OCC_W | Number of stored records |
| full | output | 1 | Table is at capacity |
| cnt_by_class | output | 4×CNT_W | Per-class die counters, index = class code |

## Verification
The bench keeps the default spare counts of one row and two columns. This makes RW 3 bits and CW 4 bits, so the stored-versus-dropped edges at row -1/-2 and column -2/-3 can each be hit with one vector. TABLE_DEPTH is lowered to 4, so the vector walk itself fills the table. The last usable dies in the walk then exercise the full-drop path while their class counters still advance. Directed runs then cover a strobe held through the busy cycle and a reset after the table is full.

// File: rtl/die_sort_pkg.sv
package die_sort_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        CLS_FREE  = 2'd0,
        CLS_SELF  = 2'd1,
        CLS_INTER = 2'd2,
        CLS_IRREP = 2'd3
    } die_class_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_JUDGE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/die_class_decide.sv
module die_class_decide
    import die_sort_pkg::*;
#(
    parameter int SPARE_ROWS = 1,
    parameter int SPARE_COLS = 2,
    parameter int RW         = 3,
    parameter int CW         = 4
) (
    input  logic                 fault,
    input  logic                 repaired,
    input  logic                 inter,
    input  logic signed [RW-1:0] row_state,
    input  logic signed [CW-1:0] col_state,
    output die_class_e           cls
);

    localparam int ROW_FLOOR = -SPARE_ROWS;
    localparam int COL_FLOOR = -SPARE_COLS;

    logic out_of_range;

    assign out_of_range = (int'(row_state) < ROW_FLOOR) || (int'(col_state) < COL_FLOOR);

    // Fixed priority: fault flag, then repair flag, then neighbour usage.
    always_comb begin
        if (!fault) begin
            cls = CLS_FREE;
        end else if (!repaired || out_of_range) begin
            cls = CLS_IRREP;
        end else if (inter) begin
            cls = CLS_INTER;
        end else begin
            cls = CLS_SELF;
        end
    end

endmodule

// File: rtl/die_record_table.sv
module die_record_table #(
    parameter int DEPTH = 8,
    parameter int REC_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [REC_W-1:0] rdata
);

    logic [REC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/die_class_recorder.sv
module die_class_recorder
    import die_sort_pkg::*;
#(
    parameter  int SPARE_ROWS  = 1,
    parameter  int SPARE_COLS  = 2,
    parameter  int TABLE_DEPTH = 8,
    parameter  int ID_W        = 8,
    parameter  int SCF_W       = 4,
    parameter  int CNT_W       = 8,
    localparam int RW          = $clog2(2*SPARE_ROWS+1) + 1,
    localparam int CW          = $clog2(2*SPARE_COLS+1) + 1,
    localparam int IDX_W       = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1,
    localparam int OCC_W       = $clog2(TABLE_DEPTH+1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [ID_W-1:0]                       in_id,
    input  logic                                  in_fault,
    input  logic                                  in_repaired,
    input  logic                                  in_inter,
    input  logic signed [RW-1:0]                  in_row,
    input  logic signed [CW-1:0]                  in_col,
    input  logic [SCF_W-1:0]                      in_scf,
    input  logic [IDX_W-1:0]                      rd_idx,
    output logic [ID_W-1:0]                       rd_id,
    output logic [1:0]                            rd_class,
    output logic signed [RW-1:0]                  rd_row,
    output logic signed [CW-1:0]                  rd_col,
    output logic [SCF_W-1:0]                      rd_scf,
    output logic [OCC_W-1:0]                      rec_count,
    output logic                                  full,
    output logic [NUM_CLASSES-1:0][CNT_W-1:0]     cnt_by_class
);

    localparam int REC_W = ID_W + 2 + RW + CW + SCF_W;

    seq_state_e state_q, state_d;
    logic       take, commit;

    logic [ID_W-1:0]        cap_id;
    logic                   cap_fault, cap_repaired, cap_inter;
    logic signed [RW-1:0]   cap_row;
    logic signed [CW-1:0]   cap_col;
    logic [SCF_W-1:0]       cap_scf;

    die_class_e             cls_now;
    logic                   store_now;
    logic [OCC_W-1:0]       occ_q;
    logic [NUM_CLASSES-1:0][CNT_W-1:0] cnt_q;

    logic signed [RW-1:0]   keep_row;
    logic signed [CW-1:0]   keep_col;
    logic [SCF_W-1:0]       keep_scf;
    logic [REC_W-1:0]       wr_rec, rd_rec;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: accept (IDLE->JUDGE), retire (JUDGE->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_JUDGE : ST_IDLE;
            ST_JUDGE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        in_ready = 1'b0;
        take     = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                take     = in_valid;
            end
            ST_JUDGE: commit = 1'b1;
            default: ;
        endcase
    end

    // Packet capture
    always_ff @(posedge clk) begin
        if (take) begin
            cap_id       <= in_id;
            cap_fault    <= in_fault;
            cap_repaired <= in_repaired;
            cap_inter    <= in_inter;
            cap_row      <= in_row;
            cap_col      <= in_col;
            cap_scf      <= in_scf;
        end
    end

    die_class_decide #(
        .SPARE_ROWS (SPARE_ROWS),
        .SPARE_COLS (SPARE_COLS),
        .RW         (RW),
        .CW         (CW)
    ) u_decide (
        .fault      (cap_fault),
        .repaired   (cap_repaired),
        .inter      (cap_inter),
        .row_state  (cap_row),
        .col_state  (cap_col),
        .cls        (cls_now)
    );

    assign full      = (occ_q == OCC_W'(TABLE_DEPTH));
    assign store_now = commit && (cls_now != CLS_IRREP) && !full;

    // A fault-free die keeps all its own spares.
    assign keep_row = (cls_now == CLS_FREE) ? RW'(SPARE_ROWS) : cap_row;
    assign keep_col = (cls_now == CLS_FREE) ? CW'(SPARE_COLS) : cap_col;
    assign keep_scf = (cls_now == CLS_FREE) ? '0 : cap_scf;
    assign wr_rec   = {cap_id, cls_now, keep_row, keep_col, keep_scf};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (store_now) begin
            occ_q <= occ_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (commit) begin
            for (int c = 0; c < NUM_CLASSES; c++) begin
                if (cls_now == die_class_e'(c)) begin
                    cnt_q[c] <= cnt_q[c] + 1'b1;
                end
            end
        end
    end

    die_record_table #(
        .DEPTH (TABLE_DEPTH),
        .REC_W (REC_W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk   (clk),
        .we    (store_now),
        .waddr (occ_q[IDX_W-1:0]),
        .wdata (wr_rec),
        .raddr (rd_idx),
        .rdata (rd_rec)
    );

    assign {rd_id, rd_class, rd_row, rd_col, rd_scf} = rd_rec;
    assign rec_count    = occ_q;
    assign cnt_by_class = cnt_q;

endmodule

// File: rtl/die_class_recorder_chk.sv
module die_class_recorder_chk
    import die_sort_pkg::*;
#(
    parameter int TABLE_DEPTH = 8,
    parameter int OCC_W       = 4,
    parameter int CNT_W       = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic                              in_ready,
    input logic [OCC_W-1:0]                  rec_count,
    input logic                              full,
    input logic [NUM_CLASSES-1:0][CNT_W-1:0] cnt_by_class,
    input logic [1:0]                        judged_class
);

    // R8: accepted packet makes the block busy next cycle
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: busy lasts one cycle
    assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R9: occupancy never exceeds capacity
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rec_count) <= TABLE_DEPTH);

    // R9: nothing is written once full
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(rec_count));

    // R3: irreparable judgement writes nothing
    assert_irrep_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && judged_class == 2'd3) |=> $stable(rec_count));

    // R11: counters only move at the end of a judge cycle
    assert_idle_counts_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> $stable(cnt_by_class));

endmodule

bind die_class_recorder die_class_recorder_chk #(
    .TABLE_DEPTH (TABLE_DEPTH),
    .OCC_W       (OCC_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .rec_count    (rec_count),
    .full         (full),
    .cnt_by_class (cnt_by_class),
    .judged_class (cls_now)
);

// File: tb/die_class_recorder_bench.sv
module die_class_recorder_bench;

    localparam int RS = 1, CS = 2, DEPTH = 4, ID_W = 8, SCF_W = 4, CNT_W = 8;
    localparam int RW = $clog2(2*RS+1) + 1;
    localparam int CW = $clog2(2*CS+1) + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH+1);
    localparam realtime HALF = 2.5ns;

    // {fault, repaired, inter, row[3], col[4], scf[4], class[2]}
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'b111, 4'b1110, 4'd3, 2'd0},  // R7 R2 no fault, repaired=0
        {1'b1, 1'b1, 1'b0, 3'b001, 4'b0000, 4'd1, 2'd1},  // R4 self
        {1'b1, 1'b1, 1'b1, 3'b111, 4'b1110, 4'd0, 2'd2},  // R5 R6 inter at floor
        {1'b1, 1'b0, 1'b1, 3'b000, 4'b0000, 4'd0, 2'd3},  // R3 not repaired
        {1'b1, 1'b1, 1'b1, 3'b110, 4'b0000, 4'd0, 2'd3},  // R6 row -2
        {1'b1, 1'b1, 1'b1, 3'b000, 4'b1101, 4'd0, 2'd3},  // R6 col -3
        {1'b1, 1'b1, 1'b1, 3'b000, 4'b0010, 4'd2, 2'd2},  // R5 fills table
        {1'b1, 1'b1, 1'b0, 3'b000, 4'b0001, 4'd1, 2'd1},  // R9 dropped, full
        {1'b0, 1'b1, 1'b1, 3'b000, 4'b0000, 4'd5, 2'd0}   // R9 R10 dropped free
    };

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_ready;
    logic [ID_W-1:0] in_id = '0, rd_id;
    logic in_fault = 1'b0, in_repaired = 1'b0, in_inter = 1'b0, full;
    logic signed [RW-1:0] in_row = '0, rd_row;
    logic signed [CW-1:0] in_col = '0, rd_col;
    logic [SCF_W-1:0] in_scf = '0, rd_scf;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [1:0] rd_class;
    logic [OCC_W-1:0] rec_count;
    logic [3:0][CNT_W-1:0] cnt_by_class;

    int n_cmp = 0, n_bad = 0, occ_exp = 0;
    int cnt_exp [4] = '{0, 0, 0, 0};
    bit done = 1'b0;

    always #HALF clk = ~clk;

    die_class_recorder #(
        .SPARE_ROWS (RS), .SPARE_COLS (CS), .TABLE_DEPTH (DEPTH),
        .ID_W (ID_W), .SCF_W (SCF_W), .CNT_W (CNT_W)
    ) u_die_class_recorder (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_id (in_id), .in_fault (in_fault), .in_repaired (in_repaired),
        .in_inter (in_inter), .in_row (in_row), .in_col (in_col), .in_scf (in_scf),
        .rd_idx (rd_idx), .rd_id (rd_id), .rd_class (rd_class), .rd_row (rd_row),
        .rd_col (rd_col), .rd_scf (rd_scf), .rec_count (rec_count), .full (full),
        .cnt_by_class (cnt_by_class)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check(int'(rec_count) == occ_exp, req, 32'(rec_count), 32'(occ_exp));
        check(full == (occ_exp == DEPTH), req, 32'(full), 32'(occ_exp == DEPTH));
        for (int c = 0; c < 4; c++)
            check(int'(cnt_by_class[c]) == cnt_exp[c], req, 32'(cnt_by_class[c]), 32'(cnt_exp[c]));
    endtask

    task automatic drive(input logic [ID_W-1:0] id, input logic [15:0] v);
        in_id = id; in_fault = v[15]; in_repaired = v[14]; in_inter = v[13];
        in_row = v[12:10]; in_col = v[9:6]; in_scf = v[5:2];
    endtask

    task automatic apply(input logic [ID_W-1:0] id, input logic [15:0] v, input string req);
        logic [1:0] cls;
        logic signed [RW-1:0] er;
        logic signed [CW-1:0] ec;
        logic [SCF_W-1:0] es;
        bit store;
        int slot;
        cls = v[1:0];
        store = (cls != 2'd3) && (occ_exp < DEPTH);
        slot = occ_exp;
        er = (cls == 2'd0) ? RW'(RS) : v[12:10];
        ec = (cls == 2'd0) ? CW'(CS) : v[9:6];
        es = (cls == 2'd0) ? '0 : v[5:2];
        @(negedge clk);
        drive(id, v); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8 busy", 32'(in_ready), 32'd0);
        @(negedge clk);
        cnt_exp[cls]++;
        if (store) occ_exp++;
        check_counts(req);
        if (store) begin
            rd_idx = IDX_W'(slot); #1;
            check({rd_id, rd_class, rd_row, rd_col, rd_scf} == {id, cls, er, ec, es},
                  req, 32'({rd_id, rd_class, rd_row, rd_col, rd_scf}), 32'({id, cls, er, ec, es}));
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'd1);
        check_counts("R1 reset");

        for (int k = 0; k < NV; k++)
            apply(ID_W'(8'h10 + k), VEC[k], $sformatf("R10 vector %0d", k));

        // R1 reset after full, table reused from slot 0
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        occ_exp = 0; cnt_exp = '{0, 0, 0, 0};
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
        check_counts("R1 counts after reset");

        // R11 strobe held during busy cycle with a different packet
        @(negedge clk);
        drive(8'hA1, {1'b1, 1'b1, 1'b0, 3'b000, 4'b0001, 4'd0, 2'd1}); in_valid = 1'b1;
        @(negedge clk);
        drive(8'hB2, {1'b1, 1'b1, 1'b1, 3'b000, 4'b0000, 4'd0, 2'd2});
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b1, "R8 ready back", 32'(in_ready), 32'd1);
        @(negedge clk);
        cnt_exp[1] = 1; occ_exp = 1;
        check_counts("R11 busy strobe ignored");
        rd_idx = '0; #1;
        check(rd_id == 8'hA1, "R11 first packet kept", 32'(rd_id), 32'hA1);

        // R9 second record lands in slot 1
        apply(8'hC3, {1'b1, 1'b1, 1'b1, 3'b111, 4'b0000, 4'd4, 2'd2}, "R9 slot order");

        summary();
    end

endmodule